// File: doc/BRIEF.md
# Add-Only Memory Byte Programming Sequencer

This block models the byte-programming path of a single-wire add-only memory. The array holds 2048 bytes in 64 pages of 32 bytes. A master sends a serial stream of bits. Each bit arrives on a one-cycle strobe, so the timing of the bit slots is abstracted away. The stream carries a write command, a 16-bit start address and a data byte. The block keeps the data byte in a one-byte scratchpad. It then returns a 16-bit check value, built from the current address and the new byte, over sixteen further strobes. After that it waits for a programming pulse, which stands in for the high-voltage programming event.

Programming can only clear bits. The stored byte becomes the old value ANDed with the scratchpad, so bytes that are already programmed stay intact and new data is only added. Each page has a protect input that blocks programming of that page. After each pulse the block reports the resulting array byte for verification. When the byte was written, the address advances and the block waits for the next data byte. The check value for that next byte is seeded from the advanced address. Reset abandons the sequence at any point and leaves the array untouched.

Top module: `aom_prog_seq`

## Requirements
- R1: During and after reset, `slot_dout` is 1, `vfy_valid` is 0, and the block waits for a command byte.
- R2: A command byte other than 0x0F makes the block ignore all later strobes and pulses until reset. In that state `slot_dout` stays 1 and `vfy_valid` stays 0.
- R3: Every byte and word is received LSB first, one bit per `slot_stb`. The command byte 0x0F is followed by a 16-bit address and then an 8-bit data byte, which goes into the scratchpad.
- R4: After the data byte, the next 16 strobes read out the inverted CRC-16, LSB first. The CRC uses polynomial x^16+x^15+x^2+1, is shifted LSB first, and starts from zero. It covers the address low byte, then the address high byte, then the data byte. `slot_dout` shows each bit before the strobe that consumes it.
- R5: `slot_din` is ignored during the CRC readout. The sequence continues whatever value the master computes.
- R6: A `prog_pulse` after the CRC readout stores old AND data. One cycle later, `vfy_valid` pulses for one cycle and `vfy_byte` holds the resulting array byte.
- R7: A bit that is 0 in the array never returns to 1.
- R8: The page is address bits [10:5]. If `page_lock` for that page is 1, the byte is unchanged, `vfy_byte` returns the old byte and the address does not advance.
- R9: After an unlocked program, the address advances by one and the block expects the next data byte. The next CRC is seeded from the advanced address. The array index is the low 11 address bits, so 0x0800 maps to byte 0.
- R10: A `prog_pulse` outside the programming wait has no effect. A `slot_stb` during the programming wait has no effect, including one that arrives in the same cycle as the pulse.
- R11: Reset aborts any phase. A pulse that coincides with reset writes nothing, and the array keeps its contents.
- R12: An unprogrammed byte reads as 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the sequence abort |
| slot_stb | input | 1 | One-cycle strobe per bit slot |
| slot_din | input | 1 | Bit written by the master in the slot |
| slot_dout | output | 1 | Bit returned by the block for the slot (1 when released) |
| prog_pulse | input | 1 | Programming event |
| page_lock | input | 64 | Per-page write protect, bit n guards page n |
| vfy_valid | output | 1 | One-cycle flag after a programming event |
| vfy_byte | output | 8 | Array byte after the programming event |

## Verification
Two pairs of events can meet in the same cycle. The bench raises a bit strobe in the same cycle as the programming pulse during the wait. It then judges the result by the verify byte and by the CRC of the following byte, which must show that the strobe was dropped. The bench also asserts reset in the same cycle as a pulse. It then reprograms the same byte with 0xFF and confirms that the array byte is unchanged. Randomly placed locked pages are mixed with unlocked ones. Each pulse is judged against a bench model of the AND rule and of the address advance.

// File: rtl/aom_pkg.sv
package aom_pkg;

  typedef enum logic [2:0] {
    ST_CMD  = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_CRC  = 3'd3,
    ST_PROG = 3'd4,
    ST_SINK = 3'd5
  } seq_st_t;

  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

  // one reflected CRC-16 step per input bit
  function automatic logic [15:0] crc16_bit(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    crc16_bit = fb ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
  endfunction

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = crc16_bit(r, b[i]);
    crc16_byte = r;
  endfunction

  // stored byte after a programming event: bits may only be cleared
  function automatic logic [7:0] add_only(input logic [7:0] old_b, input logic [7:0] new_b,
                                          input logic locked);
    add_only = locked ? old_b : (old_b & new_b);
  endfunction

endpackage

// File: rtl/aom_crc_tx.sv
module aom_crc_tx
  import aom_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic              shift,
  output logic              tx_bit
);
  localparam int ADDR_BYTES = ADDR_W / 8;

  logic [15:0] crc_calc;
  logic [15:0] sr;

  always_comb begin
    crc_calc = 16'h0000;
    for (int i = 0; i < ADDR_BYTES; i++) crc_calc = crc16_byte(crc_calc, addr[i*8 +: 8]);
    crc_calc = crc16_byte(crc_calc, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr <= 16'hFFFF;
    else if (load)   sr <= ~crc_calc;
    else if (shift)  sr <= {1'b1, sr[15:1]};
  end

  assign tx_bit = sr[0];

  // R4: a fresh load presents the inverted low CRC bit first
  assert_crc_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (tx_bit == ~$past(crc_calc[0])));

endmodule

// File: rtl/aom_array.sv
module aom_array
  import aom_pkg::*;
#(
  parameter int PAGES      = 64,
  parameter int PAGE_BYTES = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [$clog2(PAGES*PAGE_BYTES)-1:0] idx,
  input  logic [7:0]                       wdata,
  input  logic [PAGES-1:0]                 page_lock,
  output logic [7:0]                       cur_byte,
  output logic [7:0]                       new_byte,
  output logic                             blocked
);
  localparam int BYTES = PAGES * PAGE_BYTES;
  localparam int IDX_W = $clog2(BYTES);
  localparam int OFS_W = $clog2(PAGE_BYTES);

  logic [7:0] mem [BYTES];

  // unprogrammed part: every cell erased
  initial begin
    for (int i = 0; i < BYTES; i++) mem[i] = 8'hFF;
  end

  assign cur_byte = mem[idx];
  assign blocked  = page_lock[idx[IDX_W-1:OFS_W]];
  assign new_byte = add_only(cur_byte, wdata, blocked);

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= new_byte;
  end

  // R7: no programming event sets a bit that was clear
  assert_no_bit_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mem[$past(idx)] & ~$past(cur_byte)) == 8'h00));

  // R8: a protected page keeps its byte
  assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && blocked) |=> (mem[$past(idx)] == $past(cur_byte)));

endmodule

// File: rtl/aom_prog_seq.sv
module aom_prog_seq
  import aom_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          PAGES      = 64,
  parameter int          PAGE_BYTES = 32,
  parameter logic [7:0]  WR_CMD     = 8'h0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_stb,
  input  logic             slot_din,
  output logic             slot_dout,
  input  logic             prog_pulse,
  input  logic [PAGES-1:0] page_lock,
  output logic             vfy_valid,
  output logic [7:0]       vfy_byte
);
  localparam int BYTES  = PAGES * PAGE_BYTES;
  localparam int IDX_W  = $clog2(BYTES);
  localparam int SH_W   = (ADDR_W > 16) ? ADDR_W : 16;
  localparam int CNT_W  = $clog2(SH_W);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] LAST_CRC  = CNT_W'(15);

  seq_st_t           st;
  logic [CNT_W-1:0]  cnt;
  logic [SH_W-2:0]   sh;
  logic [SH_W-1:0]   rx_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        scratch;

  // named events for the assertions
  logic cmd_done, addr_done, data_done, crc_shift, crc_done, prog_fire;
  logic rx_take;
  logic crc_bit;
  logic [7:0] cur_byte, new_byte;
  logic blocked;

  assign rx_nxt    = {slot_din, sh};
  assign rx_take   = slot_stb && (st == ST_CMD || st == ST_ADDR || st == ST_DATA);
  assign cmd_done  = slot_stb && (st == ST_CMD)  && (cnt == LAST_BYTE);
  assign addr_done = slot_stb && (st == ST_ADDR) && (cnt == LAST_ADDR);
  assign data_done = slot_stb && (st == ST_DATA) && (cnt == LAST_BYTE);
  assign crc_shift = slot_stb && (st == ST_CRC);
  assign crc_done  = crc_shift && (cnt == LAST_CRC);
  assign prog_fire = prog_pulse && (st == ST_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else if (rx_take) sh <= rx_nxt[SH_W-1:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cmd_done || addr_done || data_done || crc_done) begin
      cnt <= '0;
    end else if (rx_take || crc_shift) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_CMD;
    end else begin
      unique case (st)
        ST_CMD:  if (cmd_done)  st <= (rx_nxt[SH_W-1 -: 8] == WR_CMD) ? ST_ADDR : ST_SINK;
        ST_ADDR: if (addr_done) st <= ST_DATA;
        ST_DATA: if (data_done) st <= ST_CRC;
        ST_CRC:  if (crc_done)  st <= ST_PROG;
        ST_PROG: if (prog_fire) st <= ST_DATA;
        ST_SINK: st <= ST_SINK;
        default: st <= ST_SINK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_done) begin
      addr_q <= rx_nxt[SH_W-1 -: ADDR_W];
    end else if (prog_fire && !blocked) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scratch <= 8'hFF;
    else if (data_done) scratch <= rx_nxt[SH_W-1 -: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vfy_valid <= 1'b0;
      vfy_byte  <= 8'h00;
    end else begin
      vfy_valid <= prog_fire;
      if (prog_fire) vfy_byte <= new_byte;
    end
  end

  aom_crc_tx #(.ADDR_W(ADDR_W)) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (data_done),
    .addr   (addr_q),
    .data   (rx_nxt[SH_W-1 -: 8]),
    .shift  (crc_shift),
    .tx_bit (crc_bit)
  );

  aom_array #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (prog_fire),
    .idx       (addr_q[IDX_W-1:0]),
    .wdata     (scratch),
    .page_lock (page_lock),
    .cur_byte  (cur_byte),
    .new_byte  (new_byte),
    .blocked   (blocked)
  );

  assign slot_dout = (st == ST_CRC) ? crc_bit : 1'b1;

  // R2: an unknown command is final until reset
  assert_sink_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SINK) |=> (st == ST_SINK));

  // R6: verify flag follows a programming event by one cycle with the ANDed byte
  assert_vfy_and_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_fire && !blocked) |=> (vfy_valid && vfy_byte == ($past(cur_byte) & $past(scratch))));

  // R8: a refused program keeps the address
  assert_lock_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_fire && blocked) |=> $stable(addr_q));

  // R9: an accepted program advances the address by one
  assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_fire && !blocked) |=> (addr_q == $past(addr_q) + 1'b1));

  // R10: pulses outside the wait never produce a verify flag
  assert_stray_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_pulse && st != ST_PROG) |=> !vfy_valid);

endmodule

// File: tb/tb_aom_prog_seq.sv
`timescale 1ns/1ps
module tb_aom_prog_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_stb = 1'b0;
  logic        slot_din = 1'b0;
  logic        slot_dout;
  logic        prog_pulse = 1'b0;
  logic [63:0] lock = '0;
  logic        vfy_valid;
  logic [7:0]  vfy_byte;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [7:0]  mdl [2048];
  logic [15:0] cur_addr;

  always #2.5 clk = ~clk;

  aom_prog_seq dut (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .slot_din(slot_din),
    .slot_dout(slot_dout), .prog_pulse(prog_pulse), .page_lock(lock),
    .vfy_valid(vfy_valid), .vfy_byte(vfy_byte)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // bench CRC: whole 24-bit message, polynomial taps applied explicitly
  function automatic logic [15:0] ref_crc(input logic [15:0] a, input logic [7:0] d);
    logic [23:0] msg;
    logic [15:0] c;
    logic fb;
    msg = {d, a};
    c = 16'h0000;
    for (int i = 0; i < 24; i++) begin
      fb = c[0] ^ msg[i];
      c = {fb, c[15:1]};
      c[13] = c[13] ^ fb;
      c[0]  = c[0] ^ fb;
    end
    return ~c;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; slot_stb = 1'b0; prog_pulse = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    slot_stb = 1'b1; slot_din = b;
    @(negedge clk);
    slot_stb = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic start(input logic [7:0] cmd, input logic [15:0] a);
    send_byte(cmd);
    for (int i = 0; i < 16; i++) send_bit(a[i]);
    cur_addr = a;
  endtask

  // sample before each strobe; master drives random bits meanwhile
  task automatic read_word(output logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      w[i] = slot_dout;
      slot_stb = 1'b1; slot_din = 1'($urandom);
      @(negedge clk);
      slot_stb = 1'b0;
    end
  endtask

  task automatic pulse(input bit with_stb);
    @(negedge clk);
    prog_pulse = 1'b1;
    if (with_stb) begin slot_stb = 1'b1; slot_din = 1'b0; end
    @(negedge clk);
    prog_pulse = 1'b0; slot_stb = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] d, input string tag, input bit noise);
    logic [15:0] got, exp;
    logic [10:0] ix;
    logic lk;
    logic [7:0] en;
    send_byte(d);
    read_word(got);
    exp = ref_crc(cur_addr, d);
    check(got == exp, "R3 R4 R5 crc", {16'h0, got}, {16'h0, exp});
    if (noise) begin
      for (int k = 0; k < 3; k++) send_bit(1'b0);
    end
    pulse(noise);
    ix = cur_addr[10:0];
    lk = lock[ix[10:5]];
    en = lk ? mdl[ix] : (mdl[ix] & d);
    check(vfy_valid && vfy_byte == en, tag, {23'h0, vfy_valid, vfy_byte}, {23'h0, 1'b1, en});
    mdl[ix] = en;
    if (!lk) cur_addr = cur_addr + 16'd1;
    @(negedge clk);
    check(!vfy_valid, "R6 one-cycle flag", {31'h0, vfy_valid}, 32'h0);
  endtask

  initial begin
    logic ok;
    int seed_dummy;
    seed_dummy = $urandom(32'd1789);
    for (int i = 0; i < 2048; i++) mdl[i] = 8'hFF;
    cur_addr = 16'h0;

    @(negedge clk);
    check(slot_dout == 1'b1 && vfy_valid == 1'b0, "R1 in reset", {30'h0, slot_dout, vfy_valid}, 32'h2);
    do_reset();
    check(slot_dout == 1'b1 && vfy_valid == 1'b0, "R1 after reset", {30'h0, slot_dout, vfy_valid}, 32'h2);

    // directed: basic program and sequential bytes, erased reads
    start(8'h0F, 16'h0040);
    do_byte(8'hA5, "R6 R12 first byte", 1'b0);
    do_byte(8'h3C, "R9 next address", 1'b0);
    do_byte(8'hFF, "R12 erased readback", 1'b0);

    // add-only over existing data
    do_reset();
    start(8'h0F, 16'h0040);
    do_byte(8'h0F, "R7 and with old", 1'b0);
    do_byte(8'hFF, "R7 readback kept", 1'b0);

    // locked page then unlocked
    do_reset();
    lock[3] = 1'b1;
    start(8'h0F, 16'h0060);
    do_byte(8'h00, "R8 locked unchanged", 1'b0);
    lock[3] = 1'b0;
    do_byte(8'h12, "R8 same address retried", 1'b0);

    // stray pulse in data phase, strobes in the wait, coincident strobe and pulse
    pulse(1'b0);
    check(!vfy_valid, "R10 stray pulse", {31'h0, vfy_valid}, 32'h0);
    do_byte(8'h77, "R10 noise in wait", 1'b1);
    do_byte(8'hF0, "R10 state intact", 1'b0);

    // unknown command
    do_reset();
    send_byte(8'hAA);
    ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (slot_dout !== 1'b1) ok = 1'b0;
      slot_stb = 1'b1; slot_din = 1'($urandom);
      @(negedge clk);
      slot_stb = 1'b0;
    end
    check(ok, "R2 bus released", {31'h0, ok}, 32'h1);
    pulse(1'b0);
    check(!vfy_valid, "R2 pulse ignored", {31'h0, vfy_valid}, 32'h0);

    // aborts
    do_reset();
    start(8'h0F, 16'h0100);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    do_reset();
    check(slot_dout && !vfy_valid, "R11 abort in data", {30'h0, slot_dout, vfy_valid}, 32'h2);
    start(8'h0F, 16'h0100);
    send_byte(8'h00);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    do_reset();
    start(8'h0F, 16'h0100);
    send_byte(8'h00);
    for (int i = 0; i < 16; i++) send_bit(1'b0);
    @(negedge clk);
    rst_n = 1'b0; prog_pulse = 1'b1;
    @(negedge clk);
    prog_pulse = 1'b0;
    check(!vfy_valid, "R11 pulse under reset", {31'h0, vfy_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    start(8'h0F, 16'h0100);
    do_byte(8'hFF, "R11 array kept", 1'b0);

    // wrap of the array index
    do_reset();
    start(8'h0F, 16'h07FF);
    do_byte(8'h5A, "R9 last byte", 1'b0);
    do_byte(8'hC3, "R9 index wraps", 1'b0);

    // constrained random sequences
    for (int r = 0; r < 8; r++) begin
      logic [15:0] a;
      do_reset();
      lock = {$urandom, $urandom} & {$urandom, $urandom};
      a = 16'($urandom);
      start(8'h0F, a);
      for (int b = 0; b < 4; b++) do_byte(8'($urandom), "R6 R8 R9 random", 1'b0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule